// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is the serial front end of a small I2C target that fronts a bank of four byte-wide registers. SCL and SDA are sampled in the system clock domain. The block detects start, repeated-start and stop conditions. It answers one 7-bit address, whose upper four bits are fixed and whose lower three bits come from strap pins. SDA is never driven high: the block only asserts a pull-low enable, and the board or the bench forms the wired-AND bus level.

After a write address, the first byte is a command byte. Its two low bits become a register pointer. Every later data byte of that write goes to the same register, through a one-cycle write strobe. The pointer never advances and is kept across stops and repeated starts. A read therefore returns the pointed register over and over until the master withholds its acknowledge. A capture strobe tells the register bank when the byte to be sent is being taken, so the bank can latch its input pins at that moment.

Top module: `i2c_regport_target`

## Requirements
- R1: While reset is low and on the first cycle after it, `sda_pull_o`, `wr_stb_o` and `cap_stb_o` are all 0.
- R2: An address byte equal to {0011, `addr_pins_i`, R/W} (R/W in bit 0, 1 = read) is acknowledged by pulling SDA low through the high phase of the ninth clock. Any other address gets no acknowledge, and every later byte is ignored (no acknowledge, no write strobe, no register change) until the next start or stop.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen at any point, including inside a byte, restarts address reception.
- R4: The first byte after a write address is the command byte and is acknowledged. Bits [1:0] load the register pointer on `reg_sel_o` (0 = input, 1 = output, 2 = polarity, 3 = direction), and bits [7:2] are ignored.
- R5: Each data byte after the command byte in the same write is acknowledged. While SCL is high in that byte's acknowledge clock, it is presented on `wr_data_o` with a one-cycle `wr_stb_o` for the pointed register.
- R6: The pointer keeps its value across stops and repeated starts until a new command byte is received.
- R7: In a read, the pointed register is sent MSB first, one byte per master acknowledge. After a master NACK the block releases SDA and drives nothing until the next start or stop.
- R8: `cap_stb_o` pulses while SCL is high in the address acknowledge clock of a read and in each master-ACK clock. `rd_data_i` is taken in that cycle as the next byte to send.
- R9: `sda_pull_o` changes only while SCL is low.
- R10: After a stop, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| addr_pins_i | input | 3 | Low three bits of the target address |
| reg_sel_o | output | 2 | Register pointer, used for both writes and reads |
| wr_stb_o | output | 1 | One-cycle write strobe for the pointed register |
| wr_data_o | output | 8 | Byte to write |
| rd_data_i | input | 8 | Current value of the pointed register |
| cap_stb_o | output | 1 | Capture pulse: read data is taken in this cycle |

## Verification
The hardest case to reach is a read that spans a capture boundary: the input register's value must change between two capture points, after one byte has been captured and before the next master acknowledge. The bench points at the input register, starts a read, and changes the modelled pin levels right after the address acknowledge. It then expects the old value in the first byte and the new value in the second. A second hard case is a start inside an unfinished address byte. It is produced by aborting after four address bits and checking that the next full address is still acknowledged.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the I2C register-pointer target.
package i2c_tgt_pkg;
    // Protocol phase of the target state machine.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_CMD   = 3'd2,
        PH_WDATA = 3'd3,
        PH_RDATA = 3'd4,
        PH_SKIP  = 3'd5
    } phase_e;

    // Fixed upper bits of the 7-bit target address.
    localparam int          ADDR_HI_W = 4;
    localparam logic [3:0]  ADDR_HI   = 4'b0011;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Synchronises SCL and SDA into clk and derives SCL edges and the
// start / stop bus conditions.
// Assumes the bus changes slowly compared with clk (several clocks per phase).
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int DEPTH = STAGES + 1;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            logic scl_q, sda_q;
            if (g == 0) begin : g_first
                // First flop of each line samples the raw bus.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q <= 1'b1;
                        sda_q <= 1'b1;
                    end else begin
                        scl_q <= scl_i;
                        sda_q <= sda_i;
                    end
                end
            end else begin : g_next
                // Later flops extend the chain by one stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        scl_q <= 1'b1;
                        sda_q <= 1'b1;
                    end else begin
                        scl_q <= g_stage[g-1].scl_q;
                        sda_q <= g_stage[g-1].sda_q;
                    end
                end
            end
        end
    endgenerate

    logic scl_now, scl_prev, sda_now, sda_prev;

    // Current synchronised level and the level one clock earlier.
    always_comb begin
        scl_now  = g_stage[STAGES-1].scl_q;
        sda_now  = g_stage[STAGES-1].sda_q;
        scl_prev = g_stage[STAGES].scl_q;
        sda_prev = g_stage[STAGES].sda_q;
    end

    // Edge and condition decode; data changes are meaningful only while SCL is high.
    always_comb begin
        sda_o      = sda_now;
        scl_rise_o = scl_now & ~scl_prev;
        scl_fall_o = ~scl_now & scl_prev;
        start_o    = scl_now & scl_prev & sda_prev & ~sda_now;
        stop_o     = scl_now & scl_prev & ~sda_prev & sda_now;
    end
endmodule

// File: rtl/i2c_tx_shift.sv
`timescale 1ns/1ps
// Transmit shift register for read data. Loaded in parallel, shifted
// MSB first. Ones are shifted in, so an idle register never pulls SDA.
module i2c_tx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              msb_o
);
    logic [DATA_W-1:0] sh_q;

    // Parallel load takes priority over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '1;
        else if (load_i)  sh_q <= din_i;
        else if (shift_i) sh_q <= {sh_q[DATA_W-2:0], 1'b1};
    end

    assign msb_o = sh_q[DATA_W-1];
endmodule

// File: rtl/i2c_target_ctrl.sv
`timescale 1ns/1ps
// Protocol state machine: address match, acknowledge, command pointer,
// write strobes and read sequencing.
// Assumes synchronised edge/condition pulses from i2c_line_sync and
// ADDR_HI_W + PIN_W == DATA_W - 1.
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2,
    parameter int PIN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic              tx_msb_i,
    output logic              sda_pull_o,
    output logic              tx_load_o,
    output logic              tx_shift_o,
    output logic              wr_stb_o,
    output logic              cap_stb_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [DATA_W-1:0] rx_byte_o
);
    localparam int ADDR_W = ADDR_HI_W + PIN_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    phase_e            ph_q;
    logic              ack_ph_q, ack_drv_q, dat_drv_q, rw_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [DATA_W-1:0] rx_q;
    logic [SEL_W-1:0]  ptr_q;
    logic [ADDR_W-1:0] my_addr;

    assign my_addr = {ADDR_HI, addr_pins_i};

    // Main protocol sequencer; all bus actions are taken on synchronised SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            ack_ph_q   <= 1'b0;
            ack_drv_q  <= 1'b0;
            dat_drv_q  <= 1'b0;
            rw_q       <= 1'b0;
            bit_cnt_q  <= '0;
            rx_q       <= '0;
            ptr_q      <= '0;
            wr_stb_o   <= 1'b0;
            cap_stb_o  <= 1'b0;
            tx_load_o  <= 1'b0;
            tx_shift_o <= 1'b0;
        end else begin
            wr_stb_o   <= 1'b0;
            cap_stb_o  <= 1'b0;
            tx_load_o  <= 1'b0;
            tx_shift_o <= 1'b0;
            if (start_i) begin
                ph_q      <= PH_ADDR;
                bit_cnt_q <= '0;
                ack_ph_q  <= 1'b0;
                ack_drv_q <= 1'b0;
                dat_drv_q <= 1'b0;
            end else if (stop_i) begin
                ph_q      <= PH_IDLE;
                ack_ph_q  <= 1'b0;
                ack_drv_q <= 1'b0;
                dat_drv_q <= 1'b0;
            end else if (ph_q == PH_IDLE || ph_q == PH_SKIP) begin
                ack_ph_q <= 1'b0;
            end else if (ack_ph_q) begin
                if (scl_rise_i) begin
                    unique case (ph_q)
                        PH_ADDR: begin
                            if (rw_q) begin
                                ph_q      <= PH_RDATA;
                                tx_load_o <= 1'b1;
                                cap_stb_o <= 1'b1;
                            end else begin
                                ph_q <= PH_CMD;
                            end
                        end
                        PH_CMD: begin
                            ptr_q <= rx_q[SEL_W-1:0];
                            ph_q  <= PH_WDATA;
                        end
                        PH_WDATA: wr_stb_o <= 1'b1;
                        PH_RDATA: begin
                            if (!sda_s_i) begin
                                tx_load_o <= 1'b1;
                                cap_stb_o <= 1'b1;
                            end else begin
                                ph_q     <= PH_SKIP;
                                ack_ph_q <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end else if (scl_fall_i) begin
                    ack_ph_q  <= 1'b0;
                    ack_drv_q <= 1'b0;
                    dat_drv_q <= (ph_q == PH_RDATA);
                    bit_cnt_q <= '0;
                end
            end else if (ph_q == PH_RDATA) begin
                if (scl_rise_i && bit_cnt_q != FULL) begin
                    bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                end else if (scl_fall_i) begin
                    if (bit_cnt_q == FULL) begin
                        dat_drv_q <= 1'b0;
                        ack_ph_q  <= 1'b1;
                    end else if (bit_cnt_q != '0) begin
                        tx_shift_o <= 1'b1;
                    end
                end
            end else begin
                if (scl_rise_i && bit_cnt_q != FULL) begin
                    rx_q      <= {rx_q[DATA_W-2:0], sda_s_i};
                    bit_cnt_q <= bit_cnt_q + CNT_W'(1);
                    if (bit_cnt_q == LAST) begin
                        rw_q <= sda_s_i;
                        if (ph_q == PH_ADDR && rx_q[ADDR_W-1:0] != my_addr)
                            ph_q <= PH_SKIP;
                    end
                end else if (scl_fall_i && bit_cnt_q == FULL) begin
                    ack_drv_q <= 1'b1;
                    ack_ph_q  <= 1'b1;
                end
            end
        end
    end

    // Open-drain drive: the acknowledge, or a zero data bit while transmitting.
    always_comb begin
        sda_pull_o = ack_drv_q | (dat_drv_q & ~tx_msb_i);
        sel_o      = ptr_q;
        rx_byte_o  = rx_q;
    end
endmodule

// File: rtl/i2c_regport_target.sv
`timescale 1ns/1ps
// Top of the I2C register-pointer target: line synchroniser, protocol
// controller and transmit shifter. The register bank sits outside.
// Assumes SDA is resolved externally as the wired-AND of all pull-downs.
module i2c_regport_target #(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int SEL_W       = 2,
    parameter int PIN_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [PIN_W-1:0]  addr_pins_i,
    output logic [SEL_W-1:0]  reg_sel_o,
    output logic              wr_stb_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              cap_stb_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic tx_load, tx_shift, tx_msb;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_target_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .PIN_W(PIN_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s_i     (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .addr_pins_i (addr_pins_i),
        .tx_msb_i    (tx_msb),
        .sda_pull_o  (sda_pull_o),
        .tx_load_o   (tx_load),
        .tx_shift_o  (tx_shift),
        .wr_stb_o    (wr_stb_o),
        .cap_stb_o   (cap_stb_o),
        .sel_o       (reg_sel_o),
        .rx_byte_o   (wr_data_o)
    );

    i2c_tx_shift #(.DATA_W(DATA_W)) txsh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tx_load),
        .shift_i (tx_shift),
        .din_i   (rd_data_i),
        .msb_o   (tx_msb)
    );
endmodule

// File: rtl/i2c_regport_target_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to i2c_regport_target.
// Assumes the bus master holds each SCL phase for several clocks.
module i2c_regport_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull_o,
    input logic wr_stb_o,
    input logic cap_stb_o,
    input logic stop_det
);
    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull_o);

    // R5
    wr_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> sda_pull_o);

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R8
    cap_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb_o |-> scl_i);

    // R9
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind i2c_regport_target i2c_regport_target_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull_o (sda_pull_o),
    .wr_stb_o   (wr_stb_o),
    .cap_stb_o  (cap_stb_o),
    .stop_det   (stop_det)
);

// File: tb/i2c_regport_target_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: bit-banged I2C master plus a four-register bank model.
module i2c_regport_target_tb_top;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] pins = 3'd0;
    logic [7:0] inport = 8'hC3;
    logic       sda_pull, wr_stb, cap_stb, sda_bus;
    logic [1:0] reg_sel;
    logic [7:0] wr_data, rd_data;
    logic [7:0] bank [4];

    int total = 0, fails = 0;
    int wr_cnt = 0, cap_cnt = 0, bad_edges = 0;
    logic [1:0] last_sel = '0;
    logic [7:0] last_data = '0;
    logic       prev_pull = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;
    assign rd_data = (reg_sel == 2'd0) ? inport : bank[reg_sel];

    i2c_regport_target dut_i (
        .clk (clk), .rst_n (rst_n), .scl_i (scl_m), .sda_i (sda_bus),
        .sda_pull_o (sda_pull), .addr_pins_i (pins), .reg_sel_o (reg_sel),
        .wr_stb_o (wr_stb), .wr_data_o (wr_data), .rd_data_i (rd_data),
        .cap_stb_o (cap_stb)
    );

    // Register bank model and event log seen at the ports.
    always @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= 8'h00; bank[1] <= 8'h00; bank[2] <= 8'hF0; bank[3] <= 8'hFF;
        end else begin
            if (wr_stb) begin
                wr_cnt    <= wr_cnt + 1;
                last_sel  <= reg_sel;
                last_data <= wr_data;
                if (reg_sel != 2'd0) bank[reg_sel] <= wr_data;
            end
            if (cap_stb) cap_cnt <= cap_cnt + 1;
            if (sda_pull != prev_pull && scl_m) bad_edges <= bad_edges + 1;
            prev_pull <= sda_pull;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q/2);
        ack = !sda_bus;
        tick(Q/2);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q/2);
            d[i] = sda_bus;
            tick(Q/2);
            scl_m = 1'b0;
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q/2);
        sda_m = 1'b1; tick(Q/2);
    endtask

    // Vector: [28:26] pins, [25:18] command, [17:10] data, [9:8] pointer, [7:0] read-back.
    localparam logic [28:0] VECS [5] = '{
        {3'd0, 8'h01, 8'hA5, 2'd1, 8'hA5},
        {3'd5, 8'hFE, 8'h3C, 2'd2, 8'h3C},
        {3'd7, 8'h03, 8'h81, 2'd3, 8'h81},
        {3'd2, 8'h40, 8'h77, 2'd0, 8'hC3},
        {3'd3, 8'h0D, 8'h00, 2'd1, 8'h00}
    };

    initial begin
        bit a;
        logic [7:0] d, d2;
        int w0, c0;
        logic [28:0] v;

        tick(5);
        // R1: outputs quiet in reset
        chk(sda_pull == 1'b0 && wr_stb == 1'b0 && cap_stb == 1'b0, "R1 reset", {sda_pull, wr_stb, cap_stb}, 0);
        rst_n = 1'b1;
        tick(1);
        chk(sda_pull == 1'b0 && wr_stb == 1'b0 && cap_stb == 1'b0, "R1 after reset", {sda_pull, wr_stb, cap_stb}, 0);
        tick(4);

        // Table walk: write one byte, then read it back.
        for (int k = 0; k < 5; k++) begin
            v = VECS[k];
            pins = v[28:26];
            bus_start;
            send_byte({4'b0011, v[28:26], 1'b0}, a);
            chk(a, "R2 address ack", a, 1);
            send_byte(v[25:18], a);
            chk(a, "R4 command ack", a, 1);
            w0 = wr_cnt;
            send_byte(v[17:10], a);
            chk(a, "R5 data ack", a, 1);
            bus_stop;
            chk(wr_cnt == w0 + 1 && last_sel == v[9:8], "R4 pointer from low bits", last_sel, v[9:8]);
            chk(last_data == v[17:10], "R5 write data", last_data, v[17:10]);
            bus_start;
            send_byte({4'b0011, v[28:26], 1'b1}, a);
            chk(a, "R2 read address ack", a, 1);
            recv_byte(1'b0, d);
            chk(d == v[7:0], "R7 read byte", d, v[7:0]);
            bus_stop;
        end

        // R2: mismatching address, later bytes ignored
        pins = 3'd0;
        w0 = wr_cnt;
        bus_start;
        send_byte(8'h32, a);
        chk(!a, "R2 mismatch no ack", a, 0);
        send_byte(8'h01, a);
        chk(!a, "R2 ignored byte no ack", a, 0);
        send_byte(8'hFF, a);
        chk(!a, "R2 ignored data no ack", a, 0);
        bus_stop;
        chk(wr_cnt == w0, "R2 no write strobe", wr_cnt - w0, 0);
        bus_start;
        send_byte(8'h31, a);
        recv_byte(1'b0, d);
        bus_stop;
        chk(d == 8'h00, "R2 register untouched", d, 8'h00);

        // R5: several data bytes in one write, all to the same register
        w0 = wr_cnt;
        bus_start;
        send_byte(8'h30, a);
        send_byte(8'h02, a);
        send_byte(8'h11, a);
        chk(a && last_data == 8'h11 && last_sel == 2'd2, "R5 first of burst", last_data, 8'h11);
        send_byte(8'h22, a);
        chk(a && last_data == 8'h22 && last_sel == 2'd2, "R5 second of burst", last_data, 8'h22);
        send_byte(8'h33, a);
        bus_stop;
        chk(wr_cnt == w0 + 3 && last_sel == 2'd2 && last_data == 8'h33, "R5 burst count", wr_cnt - w0, 3);

        // R6/R7/R8: pointer over a repeated start, multi-byte read, NACK release
        bus_start;
        send_byte(8'h30, a);
        send_byte(8'h02, a);
        bus_start;
        c0 = cap_cnt;
        send_byte(8'h31, a);
        chk(a, "R3 repeated start recognised", a, 1);
        recv_byte(1'b1, d);
        chk(d == 8'h33, "R6 pointer after repeated start", d, 8'h33);
        recv_byte(1'b0, d2);
        chk(d2 == 8'h33, "R7 same register again", d2, 8'h33);
        chk(cap_cnt == c0 + 2, "R8 capture count", cap_cnt - c0, 2);
        tick(Q);
        chk(sda_pull == 1'b0, "R7 released after NACK", sda_pull, 0);
        bus_stop;
        chk(sda_pull == 1'b0, "R10 released after stop", sda_pull, 0);
        bus_start;
        send_byte(8'h31, a);
        recv_byte(1'b0, d);
        bus_stop;
        chk(d == 8'h33, "R6 pointer kept across stop", d, 8'h33);

        // R8: input register changes between two capture points
        bus_start;
        send_byte(8'h30, a);
        send_byte(8'h00, a);
        bus_stop;
        inport = 8'h5A;
        bus_start;
        send_byte(8'h31, a);
        inport = 8'h96;
        recv_byte(1'b1, d);
        recv_byte(1'b0, d2);
        bus_stop;
        chk(d == 8'h5A, "R8 first capture", d, 8'h5A);
        chk(d2 == 8'h96, "R8 second capture", d2, 8'h96);

        // R3: start inside an unfinished address byte
        bus_start;
        for (int i = 7; i >= 4; i--) begin
            sda_m = 1'b0; tick(Q);
            scl_m = 1'b1; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        bus_start;
        send_byte(8'h31, a);
        chk(a, "R3 address after aborted byte", a, 1);
        recv_byte(1'b0, d);
        chk(d == 8'h96, "R3 read after abort", d, 8'h96);
        bus_stop;
        chk(sda_pull == 1'b0, "R10 idle after stop", sda_pull, 0);

        // R9: no SDA pull change while SCL high
        chk(bad_edges == 0, "R9 pull edges only with SCL low", bad_edges, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule